// File: doc/BRIEF.md
# Multi-PHY Transmit Address Match and Cell-Available Logic

This block sits at the transmit side of a cell-level ATM PHY interface. Several PHY devices can share one cell-available line. The ATM layer picks which PHY it is polling by placing a 5-bit address on a shared transmit address bus. On each rising clock edge the block samples that bus and the active-low transmit enable. It compares the address with a locally programmed station address. When this PHY is the one addressed, it drives the cell-available line, and asserts it only when the transmit FIFO has room for a complete 53-word cell.

When the address does not match, or the enable is not asserted, the block drives cell-available low and drops its output-enable flag, so that another PHY can drive the shared line. In single-PHY mode the address compare is bypassed. The block then always drives the line and reports the FIFO room alone. The station address register is loaded through a write strobe with a data port. An asynchronous active-low reset clears it to zero.

Top module: `utx_addr_clav`

## Requirements
- R1: The address bus, the enable and the FIFO free count are sampled on the rising clock edge. Both outputs change only at the edge that samples new inputs, so they lag a change of the inputs by exactly one edge.
- R2: Driving `laddr_we` high at an edge loads `laddr_wdata` into the station address register. An address compare made at that same edge still uses the previous station address. The new value applies from the next edge on.
- R3: In multi-PHY mode (`phy_mode`=1), if the sampled address equals the station address and `tx_en_n`=0, then `cell_avail_oe` becomes 1 and `cell_avail` reflects the FIFO room as defined in R7.
- R4: In multi-PHY mode, if the sampled address differs from the station address, then both `cell_avail_oe` and `cell_avail` become 0, whatever the enable and the FIFO level.
- R5: In multi-PHY mode, if the address matches but `tx_en_n`=1, then both `cell_avail_oe` and `cell_avail` become 0.
- R6: In single-PHY mode (`phy_mode`=0), the address bus and the enable have no effect. `cell_avail_oe` is 1 and `cell_avail` reflects the FIFO room alone.
- R7: The FIFO has room when `fifo_free` is 53 or more. A count of 52 or less reports no room.
- R8: Taking `rst_n` low forces both outputs to 0 at once, without waiting for a clock edge, and clears the station address to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit interface clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_mode | input | 1 | 1 = multi-PHY (address compare active), 0 = single-PHY |
| tx_addr | input | 5 | Shared transmit address bus, bit 4 most significant |
| tx_en_n | input | 1 | Active-low transmit enable from the ATM layer |
| laddr_we | input | 1 | Write strobe for the station address register |
| laddr_wdata | input | 5 | Value loaded into the station address register |
| fifo_free | input | 8 | Free words in the transmit cell FIFO |
| cell_avail | output | 1 | Cell-available flag: room for one whole cell |
| cell_avail_oe | output | 1 | High while this PHY owns the shared cell-available line |

## Verification
The assertions assume that `fifo_free` and the address bus are settled at each rising edge. They also assume that the station address changes only through the write strobe. The bench drives every input at the falling edge and samples at the next falling edge, so both conditions always hold. The sweep covers every station address against every bus address with the enable in both states, across a spread of FIFO levels. The bench also drops reset between edges, to exercise the asynchronous path without creating a race at a clock edge.

// File: rtl/utx_pkg.sv
`timescale 1ns/1ps
// utx_pkg: shared sizes and the PHY mode encoding for the transmit
// address match block. Assumes an 8-bit word interface (53-word cell).
package utx_pkg;
    parameter int ADDR_W     = 5;   // width of the shared address bus
    parameter int CNT_W      = 8;   // width of the FIFO free-word count
    parameter int CELL_WORDS = 53;  // words per cell in 8-bit mode

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_MULTI  = 1'b1
    } phy_mode_e;
endpackage

// File: rtl/utx_local_addr.sv
`timescale 1ns/1ps
// utx_local_addr: station address register of this PHY.
// Loads on a write strobe; asynchronously cleared to zero by rst_n.
// Assumes the strobe and data are stable at the rising edge.
module utx_local_addr #(
    parameter int ADDR_W = utx_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] addr
);
    // Hold the programmed station address.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  addr <= '0;
        else if (we) addr <= wdata;
    end

    AST_ADDR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (addr == $past(wdata)));                            // R2
    AST_ADDR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(addr));                                    // R2
endmodule

// File: rtl/utx_addr_cmp.sv
`timescale 1ns/1ps
// utx_addr_cmp: decides whether this PHY owns the cell-available line.
// Compares the bus address bit by bit with the station address.
// Single-PHY mode bypasses both the compare and the enable.
// Purely combinational; the result is registered downstream.
module utx_addr_cmp #(
    parameter int ADDR_W = utx_pkg::ADDR_W
) (
    input  utx_pkg::phy_mode_e mode,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [ADDR_W-1:0]  own_addr,
    input  logic               en_n,
    output logic               selected
);
    logic [ADDR_W-1:0] bit_eq;

    // One equality cell per address bit.
    for (genvar g = 0; g < ADDR_W; g++) begin : g_bit
        assign bit_eq[g] = ~(bus_addr[g] ^ own_addr[g]);
    end

    // Combine the per-bit results with the mode and the enable.
    always_comb begin
        if (mode == utx_pkg::MODE_SINGLE) selected = 1'b1;
        else                              selected = (&bit_eq) && !en_n;
    end
endmodule

// File: rtl/utx_clav_out.sv
`timescale 1ns/1ps
// utx_clav_out: registers the output-enable and the cell-available flag.
// Room means at least one whole cell of free words. Assumes fifo_free
// is a settled count at the rising edge.
module utx_clav_out #(
    parameter int CNT_W      = utx_pkg::CNT_W,
    parameter int CELL_WORDS = utx_pkg::CELL_WORDS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             selected,
    input  logic [CNT_W-1:0] fifo_free,
    output logic             clav,
    output logic             clav_oe
);
    localparam logic [CNT_W-1:0] ROOM_MIN = CNT_W'(CELL_WORDS);

    logic has_room;

    // Whole-cell room test.
    always_comb has_room = (fifo_free >= ROOM_MIN);

    // Drive the shared line only while selected; release it low otherwise.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clav    <= 1'b0;
            clav_oe <= 1'b0;
        end else begin
            clav    <= selected && has_room;
            clav_oe <= selected;
        end
    end

    AST_ROOM_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (selected && fifo_free >= ROOM_MIN) |=> clav);             // R7
    AST_NO_ROOM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_free < ROOM_MIN) |=> !clav);                         // R7
    AST_RELEASED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !clav_oe |-> !clav);                                       // R4
endmodule

// File: rtl/utx_addr_clav.sv
`timescale 1ns/1ps
// utx_addr_clav: transmit address match and cell-available top.
// Samples the address bus and the enable on each rising edge. Reports
// whole-cell FIFO room only when addressed, or always in single-PHY mode.
// Assumes all inputs are synchronous to clk.
module utx_addr_clav #(
    parameter int ADDR_W     = utx_pkg::ADDR_W,
    parameter int CNT_W      = utx_pkg::CNT_W,
    parameter int CELL_WORDS = utx_pkg::CELL_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phy_mode,
    input  logic [ADDR_W-1:0] tx_addr,
    input  logic              tx_en_n,
    input  logic              laddr_we,
    input  logic [ADDR_W-1:0] laddr_wdata,
    input  logic [CNT_W-1:0]  fifo_free,
    output logic              cell_avail,
    output logic              cell_avail_oe
);
    utx_pkg::phy_mode_e mode;
    logic [ADDR_W-1:0]  own_addr;
    logic               selected;

    // Map the mode pin onto the mode encoding.
    always_comb mode = utx_pkg::phy_mode_e'(phy_mode);

    utx_local_addr #(.ADDR_W(ADDR_W)) addr_reg_i (
        .clk(clk), .rst_n(rst_n), .we(laddr_we),
        .wdata(laddr_wdata), .addr(own_addr)
    );

    utx_addr_cmp #(.ADDR_W(ADDR_W)) cmp_i (
        .mode(mode), .bus_addr(tx_addr), .own_addr(own_addr),
        .en_n(tx_en_n), .selected(selected)
    );

    utx_clav_out #(.CNT_W(CNT_W), .CELL_WORDS(CELL_WORDS)) out_i (
        .clk(clk), .rst_n(rst_n), .selected(selected),
        .fifo_free(fifo_free), .clav(cell_avail), .clav_oe(cell_avail_oe)
    );

    AST_MATCH_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_mode && !tx_en_n && tx_addr == own_addr) |=> cell_avail_oe); // R3
    AST_MISMATCH_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_mode && tx_addr != own_addr) |=> (!cell_avail_oe && !cell_avail)); // R4
    AST_DISABLED_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_mode && tx_en_n) |=> (!cell_avail_oe && !cell_avail)); // R5
    AST_SINGLE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        !phy_mode |=> cell_avail_oe);                               // R6
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!cell_avail && !cell_avail_oe));                // R8
endmodule

// File: tb/utx_addr_clav_tb.sv
`timescale 1ns/1ps
module utx_addr_clav_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       phy_mode;
    logic [4:0] tx_addr;
    logic       tx_en_n;
    logic       laddr_we;
    logic [4:0] laddr_wdata;
    logic [7:0] fifo_free;
    logic       cell_avail;
    logic       cell_avail_oe;

    int checks   = 0;
    int failures = 0;

    always #10 clk = ~clk;   // 50 MHz

    utx_addr_clav dut_i (
        .clk(clk), .rst_n(rst_n), .phy_mode(phy_mode), .tx_addr(tx_addr),
        .tx_en_n(tx_en_n), .laddr_we(laddr_we), .laddr_wdata(laddr_wdata),
        .fifo_free(fifo_free), .cell_avail(cell_avail),
        .cell_avail_oe(cell_avail_oe)
    );

    task automatic chk(input string req, input string what,
                       input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_addr(input logic [4:0] a);
        laddr_we    = 1'b1;
        laddr_wdata = a;
        step();
        laddr_we    = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        #4_000_000;
        failures++;
        $display("FAIL watchdog run did not finish");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; phy_mode = 1'b1; tx_addr = '0; tx_en_n = 1'b1;
        laddr_we = 1'b0; laddr_wdata = '0; fifo_free = '0;
        #5;
        chk("R8", "avail in reset", cell_avail, 1'b0);
        chk("R8", "oe in reset", cell_avail_oe, 1'b0);
        step(); step();
        rst_n = 1'b1;

        // R8: station address resets to 0, so address 0 is selected
        tx_addr = 5'd0; tx_en_n = 1'b0; fifo_free = 8'd100;
        step();
        chk("R8", "oe with reset address 0", cell_avail_oe, 1'b1);
        chk("R3", "avail with room", cell_avail, 1'b1);

        // R1: no change before the edge, change after it
        tx_addr = 5'd5;
        #1;
        chk("R1", "oe held before edge", cell_avail_oe, 1'b1);
        @(negedge clk);
        chk("R1", "oe drops after edge", cell_avail_oe, 1'b0);

        // R3/R4/R5: every station address against every bus address
        for (int la = 0; la < 32; la++) begin
            write_addr(5'(la));
            for (int ta = 0; ta < 32; ta++) begin
                for (int en = 0; en < 2; en++) begin
                    logic eo, ea;
                    tx_addr   = 5'(ta);
                    tx_en_n   = (en == 0);
                    fifo_free = 8'((ta * 37 + la * 11 + en * 5) % 256);
                    eo = (ta == la) && (en == 1);
                    ea = eo && ((ta * 37 + la * 11 + en * 5) % 256 >= 53);
                    step();
                    if (ta != la) begin
                        chk("R4", "oe mismatch", cell_avail_oe, eo);
                        chk("R4", "avail mismatch", cell_avail, ea);
                    end else if (en == 1) begin
                        chk("R3", "oe match", cell_avail_oe, eo);
                        chk("R3", "avail match", cell_avail, ea);
                    end else begin
                        chk("R5", "oe disabled", cell_avail_oe, eo);
                        chk("R5", "avail disabled", cell_avail, ea);
                    end
                end
            end
        end

        // R7: threshold boundary
        write_addr(5'd7);
        tx_addr = 5'd7; tx_en_n = 1'b0;
        fifo_free = 8'd52;  step(); chk("R7", "52 free", cell_avail, 1'b0);
        fifo_free = 8'd53;  step(); chk("R7", "53 free", cell_avail, 1'b1);
        fifo_free = 8'd255; step(); chk("R7", "255 free", cell_avail, 1'b1);
        fifo_free = 8'd0;   step(); chk("R7", "0 free", cell_avail, 1'b0);

        // R6: single-PHY ignores address and enable
        phy_mode = 1'b0;
        for (int f = 0; f < 256; f++) begin
            tx_addr   = 5'((f * 13) % 32);
            tx_en_n   = f[0];
            fifo_free = 8'(f);
            step();
            chk("R6", "oe single", cell_avail_oe, 1'b1);
            chk("R6", "avail single", cell_avail, f >= 53);
        end

        // R2: compare at the write edge uses the old station address
        phy_mode = 1'b1; fifo_free = 8'd60; tx_en_n = 1'b0;
        write_addr(5'd3);
        tx_addr = 5'd3;
        write_addr(5'd9);
        chk("R2", "old address at write edge", cell_avail_oe, 1'b1);
        step();
        chk("R2", "old address no longer matches", cell_avail_oe, 1'b0);
        tx_addr = 5'd9;
        step();
        chk("R2", "new address matches", cell_avail_oe, 1'b1);
        chk("R2", "new address avail", cell_avail, 1'b1);

        // R8: asynchronous reset between edges
        #5;
        rst_n = 1'b0;
        #2;
        chk("R8", "oe async clear", cell_avail_oe, 1'b0);
        chk("R8", "avail async clear", cell_avail, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        tx_addr = 5'd0;
        step();
        chk("R8", "address cleared to 0", cell_avail_oe, 1'b1);
        tx_addr = 5'd9;
        step();
        chk("R8", "old address lost", cell_avail_oe, 1'b0);

        summary();
        $finish;
    end
endmodule